// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit linear address into a physical address by walking a two-level page table held in memory. The top ten address bits select a directory entry and the next ten select a table entry. The low twelve bits carry straight through as the offset inside the page. The walker fetches each entry through a single-word memory port. When an entry's accessed or dirty flag needs setting, it writes that entry back before moving on.

A request carries the linear address and three qualifiers: write, user mode and instruction fetch. The walker also samples the directory base, the paging-enable bit and the write-protect bit when it accepts the request. A probe qualifier lets a caller test an address without raising a fault. Each walk ends with a one-cycle completion pulse. The pulse comes with a status (failure, read-only or read/write), the physical address, and for failures the fault error code. Faults that are not probes also latch the faulting linear address.

Top module: `pt_walk2`

## Requirements
- R1: With paging disabled the physical address equals the linear address and the status is 2 (1 for an instruction fetch). No memory access is made, and `done` is high in the cycle right after the accepting clock edge.
- R2: The directory entry is read at (base with low 12 bits cleared) + 4 × linear[31:22]. The table entry is read at (directory entry with low 12 bits cleared) + 4 × linear[21:12]. The result is table-entry bits [31:12] joined with linear[11:0].
- R3: A directory base with any of bits [11:0] set ends the walk with status 0. It makes no memory access, does not pulse `fault` and leaves `fault_addr` unchanged.
- R4: A present entry (bit 0 set) whose accessed flag (bit 5) is clear is written back to the same address with bit 5 set. This applies at both levels. An entry read again with bit 5 already set is not written on a read access.
- R5: On a write access a present entry with dirty flag (bit 6) clear is written back with bits 5 and 6 set, in one write, at both levels.
- R6: An entry with bit 0 clear at either level ends the walk with status 0 and `fault` pulsed with `done`. The error code is 2 for a write plus 4 for user mode, and `fault_addr` takes the linear address. A non-present entry is never written back, and a non-present directory entry stops the walk before any table read.
- R7: A successful read reports status 1 when table-entry bit 1 (writable) is clear and 2 when it is set.
- R8: A write to a page with bit 1 clear succeeds with status 2 in supervisor mode when `wp_en` is 0. Otherwise it faults with code 3, or 7 in user mode.
- R9: With `req_probe` set, a failing walk gives status 0 and the error code, but keeps `fault` low and `fault_addr` unchanged.
- R10: An instruction fetch is treated as a read whatever `req_write` says: it sets no dirty flag, skips the protection check and returns status 1 on success.
- R11: `req_ready` is high only while idle with `done` low. `done` lasts one cycle. A memory request keeps its address and direction until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_probe | input | 1 | Suppress fault signalling |
| pdbr | input | 32 | Directory base register |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Write protect for supervisor writes |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory word address (byte units) |
| mem_req_wdata | output | 32 | Write-back entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Walk complete pulse |
| status | output | 2 | 0 fail, 1 read-only, 2 read/write |
| phys_addr | output | 32 | Translated address |
| fault | output | 1 | Page fault pulse |
| fault_code | output | 3 | Bit 0 protection, bit 1 write, bit 2 user |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
Tables in the bench memory are set up so that walks hit entries with accessed and dirty flags both clear, partly set and fully set. Counting the write-backs then separates "write when a flag is missing" from "always write" and "never write". Misses are placed at the directory level and at the table level. Comparing read counts shows whether the walk stops early. Writes to a read-only page are tried across the supervisor/user and write-protect combinations, together with the probe and fetch qualifiers, to tell the bypass, the protection fault and the suppressed fault apart. Two further cases each show that no memory traffic occurs: paging off, and an unaligned directory base. One walk runs with a stalling memory port to show that the handshake holds its request.

// File: rtl/pt_walk2_pkg.sv
package pt_walk2_pkg;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_RD   = 2'd1,
      WK_WAIT = 2'd2,
      WK_WB   = 2'd3
   } walk_st_e;

   // entry flag positions (decoded by the table format)
   localparam int ENT_P = 0;
   localparam int ENT_W = 1;
   localparam int ENT_A = 5;
   localparam int ENT_D = 6;

   // completion status encodings
   localparam logic [1:0] RES_FAIL = 2'd0;
   localparam logic [1:0] RES_RO   = 2'd1;
   localparam logic [1:0] RES_RW   = 2'd2;

   // fault code bit positions
   localparam int FC_PROT = 0;
   localparam int FC_WR   = 1;
   localparam int FC_USR  = 2;

endpackage

// File: rtl/pt_walk2_entry.sv
module pt_walk2_entry
   import pt_walk2_pkg::*;
#(
   parameter int ENT_WID = 32,
   parameter bit SET_AD  = 1'b1
) (
   input  logic [ENT_WID-1:0] ent,
   input  logic               is_wr,
   output logic               present,
   output logic               writable,
   output logic               need_wb,
   output logic [ENT_WID-1:0] ent_new
);

   assign present  = ent[ENT_P];
   assign writable = ent[ENT_W];

   generate
      if (SET_AD) begin : g_ad_update
         always_comb begin
            ent_new = ent;
            ent_new[ENT_A] = 1'b1;
            if (is_wr) ent_new[ENT_D] = 1'b1;
            need_wb = present && (!ent[ENT_A] || (is_wr && !ent[ENT_D]));
         end
         // R4: a write-back always carries the accessed flag of a present entry
         always_comb begin
            if (need_wb) begin
               p_wb_has_acc_r4: assert (ent_new[ENT_A] && ent_new[ENT_P]);
            end
         end
      end else begin : g_ad_keep
         assign ent_new = ent;
         assign need_wb = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pt_walk2_verdict.sv
module pt_walk2_verdict
   import pt_walk2_pkg::*;
(
   input  logic       pte_wr,
   input  logic       is_wr,
   input  logic       is_usr,
   input  logic       is_fetch,
   input  logic       wp,
   output logic       ok,
   output logic [1:0] res,
   output logic [2:0] code
);

   always_comb begin
      ok   = 1'b1;
      res  = pte_wr ? RES_RW : RES_RO;
      code = '0;
      if (is_fetch) begin
         res = RES_RO;
      end else if (is_wr && !pte_wr) begin
         if (!is_usr && !wp) begin
            res = RES_RW;
         end else begin
            ok   = 1'b0;
            res  = RES_FAIL;
            code[FC_PROT] = 1'b1;
            code[FC_WR]   = 1'b1;
            code[FC_USR]  = is_usr;
         end
      end
   end

endmodule

// File: rtl/pt_walk2.sv
module pt_walk2
   import pt_walk2_pkg::*;
#(
   parameter int LIN_W  = 32,
   parameter int IDX_W  = 10,
   parameter int OFS_W  = 12,
   parameter bit SET_AD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LIN_W-1:0] req_lin,
   input  logic             req_write,
   input  logic             req_user,
   input  logic             req_fetch,
   input  logic             req_probe,
   input  logic [LIN_W-1:0] pdbr,
   input  logic             pg_en,
   input  logic             wp_en,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic             mem_req_we,
   output logic [LIN_W-1:0] mem_req_addr,
   output logic [LIN_W-1:0] mem_req_wdata,
   input  logic             mem_rsp_valid,
   input  logic [LIN_W-1:0] mem_rsp_rdata,
   output logic             done,
   output logic [1:0]       status,
   output logic [LIN_W-1:0] phys_addr,
   output logic             fault,
   output logic [2:0]       fault_code,
   output logic [LIN_W-1:0] fault_addr
);

   localparam int PAD_W = LIN_W - IDX_W - 2;
   localparam int DIR_LO = LIN_W - IDX_W;

   generate
      if (LIN_W != 2*IDX_W + OFS_W) begin : g_bad_split
         $error("pt_walk2: LIN_W must equal 2*IDX_W + OFS_W");
      end
      if (OFS_W <= ENT_D) begin : g_bad_ofs
         $error("pt_walk2: OFS_W too small for entry flags");
      end
      if (IDX_W + 2 > OFS_W) begin : g_bad_idx
         $error("pt_walk2: table of IDX_W entries exceeds one page");
      end
   endgenerate

   walk_st_e         state;
   logic             lvl;
   logic [LIN_W-1:0] cur_addr, ent_q, lin_q;
   logic             wr_q, usr_q, fetch_q, probe_q, wp_q;

   logic [LIN_W-1:0] ent_sel, ent_new, dir_addr, tbl_addr;
   logic             e_present, e_writable, e_need_wb, eff_wr, step;
   logic             v_ok;
   logic [1:0]       v_res;
   logic [2:0]       v_code, miss_code;

   assign eff_wr  = wr_q && !fetch_q;
   assign ent_sel = (state == WK_WB) ? ent_q : mem_rsp_rdata;

   assign dir_addr = {pdbr[LIN_W-1:OFS_W], {OFS_W{1'b0}}}
                   + {{PAD_W{1'b0}}, req_lin[LIN_W-1:DIR_LO], 2'b00};
   assign tbl_addr = {ent_sel[LIN_W-1:OFS_W], {OFS_W{1'b0}}}
                   + {{PAD_W{1'b0}}, lin_q[OFS_W+IDX_W-1:OFS_W], 2'b00};

   always_comb begin
      miss_code = '0;
      miss_code[FC_WR]  = eff_wr;
      miss_code[FC_USR] = usr_q;
   end

   pt_walk2_entry #(.ENT_WID(LIN_W), .SET_AD(SET_AD)) u_entry (
      .ent      (ent_sel),
      .is_wr    (eff_wr),
      .present  (e_present),
      .writable (e_writable),
      .need_wb  (e_need_wb),
      .ent_new  (ent_new)
   );

   pt_walk2_verdict u_verdict (
      .pte_wr   (e_writable),
      .is_wr    (wr_q),
      .is_usr   (usr_q),
      .is_fetch (fetch_q),
      .wp       (wp_q),
      .ok       (v_ok),
      .res      (v_res),
      .code     (v_code)
   );

   // an entry is finished with once read clean or once its write-back is taken
   assign step = ((state == WK_WAIT) && mem_rsp_valid && e_present && !e_need_wb)
              || ((state == WK_WB) && mem_req_ready);

   assign req_ready     = (state == WK_IDLE) && !done;
   assign mem_req_valid = (state == WK_RD) || (state == WK_WB);
   assign mem_req_we    = (state == WK_WB);
   assign mem_req_addr  = cur_addr;
   assign mem_req_wdata = ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= WK_IDLE;
         lvl        <= 1'b0;
         cur_addr   <= '0;
         ent_q      <= '0;
         lin_q      <= '0;
         wr_q       <= 1'b0;
         usr_q      <= 1'b0;
         fetch_q    <= 1'b0;
         probe_q    <= 1'b0;
         wp_q       <= 1'b0;
         done       <= 1'b0;
         status     <= RES_FAIL;
         phys_addr  <= '0;
         fault      <= 1'b0;
         fault_code <= '0;
         fault_addr <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         case (state)
            WK_IDLE: begin
               if (req_valid && req_ready) begin
                  lin_q   <= req_lin;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  fetch_q <= req_fetch;
                  probe_q <= req_probe;
                  wp_q    <= wp_en;
                  if (!pg_en) begin
                     done       <= 1'b1;
                     status     <= req_fetch ? RES_RO : RES_RW;
                     phys_addr  <= req_lin;
                     fault_code <= '0;
                  end else if (|pdbr[OFS_W-1:0]) begin
                     done       <= 1'b1;
                     status     <= RES_FAIL;
                     fault_code <= '0;
                  end else begin
                     state    <= WK_RD;
                     lvl      <= 1'b0;
                     cur_addr <= dir_addr;
                  end
               end
            end
            WK_RD: begin
               if (mem_req_ready) state <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!e_present) begin
                     state      <= WK_IDLE;
                     done       <= 1'b1;
                     status     <= RES_FAIL;
                     fault_code <= miss_code;
                     if (!probe_q) begin
                        fault      <= 1'b1;
                        fault_addr <= lin_q;
                     end
                  end else if (e_need_wb) begin
                     ent_q <= ent_new;
                     state <= WK_WB;
                  end
               end
            end
            default: ;
         endcase

         if (step) begin
            if (!lvl) begin
               lvl      <= 1'b1;
               cur_addr <= tbl_addr;
               state    <= WK_RD;
            end else begin
               state <= WK_IDLE;
               done  <= 1'b1;
               if (v_ok) begin
                  status     <= v_res;
                  phys_addr  <= {ent_sel[LIN_W-1:OFS_W], lin_q[OFS_W-1:0]};
                  fault_code <= '0;
               end else begin
                  status     <= RES_FAIL;
                  fault_code <= v_code;
                  if (!probe_q) begin
                     fault      <= 1'b1;
                     fault_addr <= lin_q;
                  end
               end
            end
         end
      end
   end

   // R1: paging off answers directly with the linear address
   p_flat_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_IDLE && req_valid && req_ready && !pg_en)
      |=> (done && phys_addr == $past(req_lin) && !mem_req_valid));

   // R3: misaligned base ends quietly with no traffic
   p_bad_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_IDLE && req_valid && req_ready && pg_en && (|pdbr[OFS_W-1:0]))
      |=> (done && status == RES_FAIL && !fault && !mem_req_valid));

   // R6: a fault is reported only with a failed completion and latches the address
   p_fault_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && status == RES_FAIL && fault_addr == lin_q));

   // R9: probe walks never pulse fault
   p_probe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && probe_q) |-> !fault);

   // R11: done is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: no new request is taken while memory traffic is in flight
   p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R11: a stalled memory request holds its address and direction
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

endmodule

// File: tb/pt_walk2_tb_top.sv
module pt_walk2_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic        req_fetch = 1'b0, req_probe = 1'b0;
   logic [31:0] req_lin = '0, pdbr = 32'h0000_1000;
   logic        pg_en = 1'b1, wp_en = 1'b0;
   logic        req_ready, mem_req_valid, mem_req_we, done, fault;
   logic [31:0] mem_req_addr, mem_req_wdata, phys_addr, fault_addr;
   logic [1:0]  status;
   logic [2:0]  fault_code;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic        mem_req_ready;

   always #2.5 clk = ~clk;

   pt_walk2 dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
      .req_fetch(req_fetch), .req_probe(req_probe), .pdbr(pdbr), .pg_en(pg_en),
      .wp_en(wp_en), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .done(done), .status(status),
      .phys_addr(phys_addr), .fault(fault), .fault_code(fault_code),
      .fault_addr(fault_addr)
   );

   // memory model: 16 KiB of words, one-cycle read latency, optional stalls
   logic [31:0] mem [0:4095];
   int          rd_cnt = 0, wr_cnt = 0;
   logic        stall_en = 1'b0;
   logic [7:0]  lfsr = 8'hA5;

   assign mem_req_ready = !stall_en || lfsr[0];

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            mem[mem_req_addr[13:2]] <= mem_req_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem[mem_req_addr[13:2]];
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   int checks = 0, errors = 0;
   logic [1:0]  r_status;
   logic [31:0] r_phys, r_fa;
   logic        r_fault, r_ready_ok, r_drop_ok;
   logic [2:0]  r_code;
   int          r_rd, r_wr, r_lat;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] v);
      mem[a[13:2]] = v;
   endtask

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem[a[13:2]];
   endfunction

   function automatic logic [31:0] mk_lin(input int d, input int t, input int o);
      return (32'(d) << 22) | (32'(t) << 12) | 32'(o);
   endfunction

   task automatic walk(input logic [31:0] lin, input logic wr, input logic usr,
                       input logic fe, input logic pr);
      int rd0, wr0, n;
      rd0 = rd_cnt;
      wr0 = wr_cnt;
      r_ready_ok = (req_ready === 1'b1);
      req_lin = lin; req_write = wr; req_user = usr; req_fetch = fe; req_probe = pr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (done !== 1'b1 && n < 500) begin
         if (req_ready !== 1'b0) r_ready_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      if (n >= 500) chk("R11 walk timeout", 32'(n), 32'd0);
      r_lat = n; r_status = status; r_phys = phys_addr; r_fault = fault;
      r_code = fault_code; r_fa = fault_addr;
      r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
      @(negedge clk);
      r_drop_ok = (done === 1'b0);
   endtask

   task automatic t_reset;
      chk("R11 reset done", 32'(done), 32'd0);
      chk("R11 reset fault", 32'(fault), 32'd0);
      chk("R11 reset memreq", 32'(mem_req_valid), 32'd0);
      chk("R11 reset ready", 32'(req_ready), 32'd1);
   endtask

   task automatic t_first_read;   // R2 R4 R7
      logic [31:0] l;
      l = mk_lin(3, 5, 12'h234);
      walk(l, 0, 0, 0, 0);
      chk("R2 phys", r_phys, 32'hABCD_E234);
      chk("R7 ro status", 32'(r_status), 32'd1);
      chk("R2 reads", 32'(r_rd), 32'd2);
      chk("R4 writebacks", 32'(r_wr), 32'd2);
      chk("R4 pde acc", peek(32'h100C), 32'h0000_2023);
      chk("R4 pte acc", peek(32'h2014), 32'hABCD_E021);
      chk("R11 ready low busy", 32'(r_ready_ok), 32'd1);
      chk("R11 done one cycle", 32'(r_drop_ok), 32'd1);
      walk(l, 0, 0, 0, 0);
      chk("R4 no rewrite", 32'(r_wr), 32'd0);
      chk("R4 repeat phys", r_phys, 32'hABCD_E234);
   endtask

   task automatic t_dirty_stall;  // R5 R11
      stall_en = 1'b1;
      walk(mk_lin(4, 6, 12'h0AB), 1, 1, 0, 0);
      stall_en = 1'b0;
      chk("R5 status", 32'(r_status), 32'd2);
      chk("R5 phys", r_phys, 32'h1234_50AB);
      chk("R5 writebacks", 32'(r_wr), 32'd2);
      chk("R5 pde dirty", peek(32'h1010), 32'h0000_3063);
      chk("R5 pte dirty", peek(32'h3018), 32'h1234_5063);
      chk("R11 stall fault", 32'(r_fault), 32'd0);
   endtask

   task automatic t_miss;         // R6
      logic [31:0] l;
      l = mk_lin(7, 0, 12'h123);
      walk(l, 1, 1, 0, 0);
      chk("R6 pde miss fault", 32'(r_fault), 32'd1);
      chk("R6 pde miss code", 32'(r_code), 32'd6);
      chk("R6 pde miss addr", r_fa, l);
      chk("R6 pde miss status", 32'(r_status), 32'd0);
      chk("R6 pde miss reads", 32'(r_rd), 32'd1);
      chk("R6 pde miss writes", 32'(r_wr), 32'd0);
      l = mk_lin(3, 9, 12'h010);
      walk(l, 0, 0, 0, 0);
      chk("R6 pte miss code", 32'(r_code), 32'd0);
      chk("R6 pte miss fault", 32'(r_fault), 32'd1);
      chk("R6 pte miss addr", r_fa, l);
      chk("R6 pte miss reads", 32'(r_rd), 32'd2);
      chk("R6 pte untouched", peek(32'h2024), 32'h5000_0000);
   endtask

   task automatic t_protect;      // R8 R7
      logic [31:0] l;
      l = mk_lin(3, 5, 12'h234);
      wp_en = 1'b0;
      walk(l, 1, 0, 0, 0);
      chk("R8 bypass status", 32'(r_status), 32'd2);
      chk("R8 bypass fault", 32'(r_fault), 32'd0);
      chk("R5 pte dirty ro", peek(32'h2014), 32'hABCD_E061);
      wp_en = 1'b1;
      walk(l, 1, 0, 0, 0);
      chk("R8 wp code", 32'(r_code), 32'd3);
      chk("R8 wp fault", 32'(r_fault), 32'd1);
      chk("R8 wp addr", r_fa, l);
      wp_en = 1'b0;
      walk(l, 1, 1, 0, 0);
      chk("R8 user code", 32'(r_code), 32'd7);
      walk(l, 0, 1, 0, 0);
      chk("R7 user read", 32'(r_status), 32'd1);
   endtask

   task automatic t_probe;        // R9
      logic [31:0] prev;
      prev = fault_addr;
      walk(mk_lin(7, 0, 12'h123), 0, 1, 0, 1);
      chk("R9 miss status", 32'(r_status), 32'd0);
      chk("R9 miss no fault", 32'(r_fault), 32'd0);
      chk("R9 miss code", 32'(r_code), 32'd4);
      chk("R9 addr kept", r_fa, prev);
      walk(mk_lin(3, 5, 0), 1, 1, 0, 1);
      chk("R9 prot no fault", 32'(r_fault), 32'd0);
      chk("R9 prot code", 32'(r_code), 32'd7);
   endtask

   task automatic t_fetch;        // R10
      wp_en = 1'b1;
      walk(mk_lin(3, 10, 12'h008), 1, 1, 1, 0);
      wp_en = 1'b0;
      chk("R10 status", 32'(r_status), 32'd1);
      chk("R10 phys", r_phys, 32'h7777_7008);
      chk("R10 no fault", 32'(r_fault), 32'd0);
      chk("R10 no writes", 32'(r_wr), 32'd0);
      chk("R10 pte kept", peek(32'h2028), 32'h7777_7021);
   endtask

   task automatic t_flat;         // R1
      pg_en = 1'b0;
      walk(32'hDEAD_BEEF, 1, 1, 0, 0);
      chk("R1 phys", r_phys, 32'hDEAD_BEEF);
      chk("R1 status", 32'(r_status), 32'd2);
      chk("R1 no reads", 32'(r_rd + r_wr), 32'd0);
      chk("R1 latency", 32'(r_lat), 32'd1);
      chk("R11 flat done one cycle", 32'(r_drop_ok), 32'd1);
      walk(32'h0000_4321, 0, 0, 1, 0);
      chk("R1 fetch status", 32'(r_status), 32'd1);
      pg_en = 1'b1;
   endtask

   task automatic t_bad_base;     // R3
      logic [31:0] prev;
      prev = fault_addr;
      pdbr = 32'h0000_1004;
      walk(mk_lin(3, 5, 0), 0, 0, 0, 0);
      pdbr = 32'h0000_1000;
      chk("R3 status", 32'(r_status), 32'd0);
      chk("R3 no fault", 32'(r_fault), 32'd0);
      chk("R3 no access", 32'(r_rd + r_wr), 32'd0);
      chk("R3 addr kept", r_fa, prev);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      poke(32'h100C, 32'h0000_2003);
      poke(32'h2014, 32'hABCD_E001);
      poke(32'h2024, 32'h5000_0000);
      poke(32'h2028, 32'h7777_7021);
      poke(32'h1010, 32'h0000_3023);
      poke(32'h3018, 32'h1234_5003);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_read();
      t_dirty_stall();
      t_miss();
      t_protect();
      t_probe();
      t_fetch();
      t_flat();
      t_bad_base();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule